// File: doc/BRIEF.md
# Predicated Element Select Unit

This unit executes a single vector select instruction per cycle against a local file of 32 vector registers, each 128 bits wide, and a local file of 16 predicate registers, each 16 bits wide. It decodes the 32-bit instruction word, confirms the fixed opcode bits and reads both source vectors and the predicate. It then builds a result vector one element at a time. Each element comes from the first source when its predicate bit is set and from the second source when it is clear. The merged vector is written to the destination register at the clock edge that accepts the instruction.

The element width is picked per instruction and can be 8, 16, 32 or 64 bits. The predicate holds one bit for each byte of the vector. Only the bit at the lowest byte of each element decides the source for that element. An instruction whose destination equals its second source behaves as a predicated move, and the unit reports this on a flag. Instructions that do not match the opcode, or that arrive while the unit is disabled, are reported as undefined and leave every register unchanged. A preload write port for each file and one vector readback port give the surrounding logic access to the register state.

Top module: `vsel_unit`

## Requirements
- R1: An instruction is recognised only when bits 31..24 equal 8'b00000101, bit 21 is 1 and bits 15..14 equal 2'b11. Any other value in these bits raises out_undef and writes no register.
- R2: The fields are decoded by position. The destination register is bits 4..0, the first source is bits 9..5, the predicate register is bits 13..10, the second source is bits 20..16 and the size code is bits 23..22.
- R3: The size code selects the element width as 8 << code. Code 0 gives 8 bits (16 elements), code 1 gives 16 bits (8 elements), code 2 gives 32 bits (4 elements) and code 3 gives 64 bits (2 elements).
- R4: Element e is active when predicate bit e*(width/8) is set. The other predicate bits that fall inside the element have no effect on the result.
- R5: Each active element of the destination is taken from the first source, and each inactive element is taken from the second source.
- R6: out_mov_alias is 1 in the done cycle of an executed instruction whose destination number equals its second source number, and 0 in every other cycle.
- R7: While unit_en is 0, an accepted instruction raises out_undef and writes no register.
- R8: Both sources are read before the destination is written. A destination that also names the first or the second source therefore receives the correct merge of the old values.
- R9: out_done is 1 in the cycle after each cycle in which in_valid is 1, and 0 otherwise. Instructions on consecutive cycles each complete, and out_undef and out_mov_alias are valid together with out_done.
- R10: After reset, out_done, out_undef and out_mov_alias are 0.
- R11: A preload write takes effect at the clock edge. After that edge, rb_data shows the new contents of the register selected by rb_idx with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| unit_en | input | 1 | Unit enable; when 0, instructions are reported undefined |
| in_valid | input | 1 | Instruction word present this cycle |
| in_instr | input | 32 | Instruction word |
| out_done | output | 1 | Instruction accepted in the previous cycle has completed |
| out_undef | output | 1 | Completed instruction was undefined or the unit was disabled |
| out_mov_alias | output | 1 | Completed instruction was the predicated move form |
| pl_v_we | input | 1 | Vector preload write enable |
| pl_v_idx | input | 5 | Vector preload register number |
| pl_v_data | input | 128 | Vector preload data |
| pl_p_we | input | 1 | Predicate preload write enable |
| pl_p_idx | input | 4 | Predicate preload register number |
| pl_p_data | input | 16 | Predicate preload data |
| rb_idx | input | 5 | Vector readback register number |
| rb_data | output | 128 | Vector readback data |

## Verification
The merge is tried at all four element widths with mixed predicate patterns. A fault in size decoding or in the byte-to-element mapping therefore shows up as a misplaced lane. Predicates that set only the non-lowest bits of each element, together with predicates that set only the lowest bit, separate a correct lowest-byte rule from one that ORs or picks another bit of the element. Runs where the destination names the second source or the first source check the move flag and confirm that the write-after-read order is correct. Corrupting each fixed opcode field in turn, and clearing the enable, shows that the destination keeps its old value whenever out_undef is raised.

// File: rtl/vsel_pkg.sv
package vsel_pkg;
  localparam int VLEN   = 128;
  localparam int NVREG  = 32;
  localparam int NPREG  = 16;
  localparam int IW     = 32;
  localparam int VBYTES = VLEN / 8;
  localparam int VIDX_W = $clog2(NVREG);
  localparam int PIDX_W = $clog2(NPREG);

  typedef enum logic [1:0] {
    ESZ_B = 2'd0,
    ESZ_H = 2'd1,
    ESZ_W = 2'd2,
    ESZ_D = 2'd3
  } esz_e;

  typedef struct packed {
    logic              match;
    esz_e              esz;
    logic [VIDX_W-1:0] rd;
    logic [VIDX_W-1:0] rn;
    logic [VIDX_W-1:0] rm;
    logic [PIDX_W-1:0] pv;
  } dec_t;
endpackage

// File: rtl/vsel_decode.sv
module vsel_decode
  import vsel_pkg::*;
(
  input  logic [IW-1:0] instr,
  output dec_t          dec
);
  logic top_ok;
  logic mid_ok;
  logic low_ok;

  always_comb begin
    top_ok    = (instr[31:24] == 8'b0000_0101);
    mid_ok    = instr[21];
    low_ok    = (instr[15:14] == 2'b11);
    dec.match = top_ok && mid_ok && low_ok;
    dec.esz   = esz_e'(instr[23:22]);
    dec.rm    = instr[20:16];
    dec.pv    = instr[13:10];
    dec.rn    = instr[9:5];
    dec.rd    = instr[4:0];
  end
endmodule

// File: rtl/vsel_merge.sv
module vsel_merge
  import vsel_pkg::*;
#(
  parameter int W = VLEN
) (
  input  esz_e           esz,
  input  logic [W/8-1:0] pred,
  input  logic [W-1:0]   src_a,
  input  logic [W-1:0]   src_b,
  output logic [W-1:0]   res
);
  localparam int NB = W / 8;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    localparam int LO_H = (b / 2) * 2;
    localparam int LO_W = (b / 4) * 4;
    localparam int LO_D = (b / 8) * 8;
    logic take_a;

    always_comb begin
      case (esz)
        ESZ_B:   take_a = pred[b];
        ESZ_H:   take_a = pred[LO_H];
        ESZ_W:   take_a = pred[LO_W];
        default: take_a = pred[LO_D];
      endcase
      res[b*8 +: 8] = take_a ? src_a[b*8 +: 8] : src_b[b*8 +: 8];
    end
  end
endmodule

// File: rtl/vsel_regfile.sv
module vsel_regfile #(
  parameter int NREG = 32,
  parameter int W    = 128,
  parameter int NRD  = 1,
  localparam int AW  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              we_a,
  input  logic [AW-1:0]     wa_a,
  input  logic [W-1:0]      wd_a,
  input  logic              we_b,
  input  logic [AW-1:0]     wa_b,
  input  logic [W-1:0]      wd_b,
  input  logic [NRD*AW-1:0] ra,
  output logic [NRD*W-1:0]  rd
);
  logic [W-1:0] mem [NREG];

  for (genvar r = 0; r < NREG; r++) begin : g_ent
    logic hit_a;
    logic hit_b;
    assign hit_a = we_a && (wa_a == AW'(r));
    assign hit_b = we_b && (wa_b == AW'(r));

    always_ff @(posedge clk) begin
      if (hit_a) begin
        mem[r] <= wd_a;
      end else if (hit_b) begin
        mem[r] <= wd_b;
      end
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd[p*W +: W] = mem[ra[p*AW +: AW]];
  end
endmodule

// File: rtl/vsel_unit.sv
module vsel_unit
  import vsel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              unit_en,
  input  logic              in_valid,
  input  logic [IW-1:0]     in_instr,
  output logic              out_done,
  output logic              out_undef,
  output logic              out_mov_alias,
  input  logic              pl_v_we,
  input  logic [VIDX_W-1:0] pl_v_idx,
  input  logic [VLEN-1:0]   pl_v_data,
  input  logic              pl_p_we,
  input  logic [PIDX_W-1:0] pl_p_idx,
  input  logic [VBYTES-1:0] pl_p_data,
  input  logic [VIDX_W-1:0] rb_idx,
  output logic [VLEN-1:0]   rb_data
);
  // reset synchronizer: async assert, sync release
  logic rst_s1;
  logic rst_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_ok <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_ok <= rst_s1;
    end
  end

  dec_t dec;
  vsel_decode u_dec (.instr(in_instr), .dec(dec));

  logic [3*VIDX_W-1:0] v_ra;
  logic [3*VLEN-1:0]   v_rd;
  logic [VLEN-1:0]     src_a;
  logic [VLEN-1:0]     src_b;
  logic [VBYTES-1:0]   pred;
  logic [VLEN-1:0]     merged;
  logic                legal;
  logic                exec_we;

  assign v_ra    = {rb_idx, dec.rm, dec.rn};
  assign src_a   = v_rd[0 +: VLEN];
  assign src_b   = v_rd[VLEN +: VLEN];
  assign rb_data = v_rd[2*VLEN +: VLEN];
  assign legal   = unit_en && dec.match;
  assign exec_we = in_valid && legal;

  vsel_regfile #(.NREG(NVREG), .W(VLEN), .NRD(3)) u_vrf (
    .clk (clk),
    .we_a(exec_we), .wa_a(dec.rd), .wd_a(merged),
    .we_b(pl_v_we), .wa_b(pl_v_idx), .wd_b(pl_v_data),
    .ra  (v_ra), .rd(v_rd)
  );

  vsel_regfile #(.NREG(NPREG), .W(VBYTES), .NRD(1)) u_prf (
    .clk (clk),
    .we_a(1'b0), .wa_a('0), .wd_a('0),
    .we_b(pl_p_we), .wa_b(pl_p_idx), .wd_b(pl_p_data),
    .ra  (dec.pv), .rd(pred)
  );

  vsel_merge #(.W(VLEN)) u_merge (
    .esz(dec.esz), .pred(pred), .src_a(src_a), .src_b(src_b), .res(merged)
  );

  // next-state
  logic done_d, undef_d, alias_d;
  always_comb begin
    done_d  = in_valid;
    undef_d = in_valid && !legal;
    alias_d = exec_we && (dec.rd == dec.rm);
  end

  // status registers
  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      out_done      <= 1'b0;
      out_undef     <= 1'b0;
      out_mov_alias <= 1'b0;
    end else begin
      out_done      <= done_d;
      out_undef     <= undef_d;
      out_mov_alias <= alias_d;
    end
  end

  assert_done_follows_valid_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    in_valid |=> out_done);
  assert_done_needs_valid_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    out_done |-> $past(in_valid));
  assert_disabled_undef_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && !unit_en) |=> out_undef);
  assert_bad_opcode_undef_R1: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && !dec.match) |=> out_undef);
  assert_alias_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    out_mov_alias |-> (out_done && !out_undef));
endmodule

// File: tb/vsel_unit_bench.sv
module vsel_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         unit_en;
  logic         in_valid;
  logic [31:0]  in_instr;
  logic         out_done, out_undef, out_mov_alias;
  logic         pl_v_we;
  logic [4:0]   pl_v_idx;
  logic [127:0] pl_v_data;
  logic         pl_p_we;
  logic [3:0]   pl_p_idx;
  logic [15:0]  pl_p_data;
  logic [4:0]   rb_idx;
  logic [127:0] rb_data;

  int n_chk = 0;
  int n_bad = 0;
  bit summary_done = 0;

  logic [127:0] vm [32];
  logic [15:0]  pm [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  vsel_unit u_vsel_unit (
    .clk(clk), .rst_n(rst_n), .unit_en(unit_en), .in_valid(in_valid), .in_instr(in_instr),
    .out_done(out_done), .out_undef(out_undef), .out_mov_alias(out_mov_alias),
    .pl_v_we(pl_v_we), .pl_v_idx(pl_v_idx), .pl_v_data(pl_v_data),
    .pl_p_we(pl_p_we), .pl_p_idx(pl_p_idx), .pl_p_data(pl_p_data),
    .rb_idx(rb_idx), .rb_data(rb_data)
  );

  task automatic check(string req, string what, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(logic [1:0] sz, logic [4:0] m, logic [3:0] v,
                                      logic [4:0] n, logic [4:0] d);
    return {8'b0000_0101, sz, 1'b1, m, 2'b11, v, n, d};
  endfunction

  function automatic logic [127:0] exp_sel(logic [1:0] sz, logic [15:0] p,
                                           logic [127:0] a, logic [127:0] b);
    logic [127:0] r;
    int eb = 1 << sz;
    for (int i = 0; i < 16; i++) begin
      int lo = i - (i % eb);
      r[i*8 +: 8] = p[lo] ? a[i*8 +: 8] : b[i*8 +: 8];
    end
    return r;
  endfunction

  task automatic read_v(int idx, string req);
    rb_idx = 5'(idx);
    #1;
    check(req, $sformatf("vreg %0d", idx), rb_data, vm[idx]);
  endtask

  task automatic load_v(int idx, logic [127:0] val);
    @(negedge clk);
    pl_v_we = 1; pl_v_idx = 5'(idx); pl_v_data = val;
    @(negedge clk);
    pl_v_we = 0;
    vm[idx] = val;
  endtask

  task automatic load_p(int idx, logic [15:0] val);
    @(negedge clk);
    pl_p_we = 1; pl_p_idx = 4'(idx); pl_p_data = val;
    @(negedge clk);
    pl_p_we = 0;
    pm[idx] = val;
  endtask

  // issue one instruction, update model, check flags and destination
  task automatic issue(string req, logic [31:0] ins, logic en, logic exp_und, logic exp_al,
                       logic [1:0] sz, logic [4:0] m, logic [3:0] v, logic [4:0] n,
                       logic [4:0] d);
    logic [127:0] nv;
    nv = exp_sel(sz, pm[v], vm[n], vm[m]);
    @(negedge clk);
    unit_en = en; in_valid = 1; in_instr = ins;
    @(negedge clk);
    in_valid = 0;
    if (!exp_und) vm[d] = nv;
    check(req, "done", 128'(out_done), 128'(1'b1));
    check(req, "undef", 128'(out_undef), 128'(exp_und));
    check(req, "alias", 128'(out_mov_alias), 128'(exp_al));
    read_v(d, req);
    unit_en = 1;
  endtask

  task automatic t_reset;
    check("R10", "done after reset", 128'(out_done), 0);
    check("R10", "undef after reset", 128'(out_undef), 0);
    check("R10", "alias after reset", 128'(out_mov_alias), 0);
  endtask

  task automatic t_preload;
    for (int i = 0; i < 32; i++) load_v(i, {$urandom, $urandom, $urandom, $urandom});
    for (int i = 0; i < 16; i++) load_p(i, 16'($urandom));
    for (int i = 0; i < 32; i += 7) read_v(i, "R11");
  endtask

  task automatic t_sizes;
    load_p(3, 16'hA5C3);
    load_p(4, 16'h3C96);
    for (int s = 0; s < 4; s++) begin
      issue("R3 R5 R2", enc(2'(s), 5'd2, 4'd3, 5'd1, 5'(10 + s)), 1, 0, 0,
            2'(s), 5'd2, 4'd3, 5'd1, 5'(10 + s));
      issue("R3 R5", enc(2'(s), 5'd7, 4'd4, 5'd6, 5'(20 + s)), 1, 0, 0,
            2'(s), 5'd7, 4'd4, 5'd6, 5'(20 + s));
    end
  endtask

  task automatic t_lowbit;
    load_p(5, 16'hFEFE);
    load_p(6, 16'h0101);
    load_p(7, 16'h1111);
    issue("R4 upper bits only, d", enc(2'd3, 5'd8, 4'd5, 5'd9, 5'd14), 1, 0, 0,
          2'd3, 5'd8, 4'd5, 5'd9, 5'd14);
    check("R4", "no active lane", vm[14], vm[8]);
    issue("R4 lowest bit only, d", enc(2'd3, 5'd8, 4'd6, 5'd9, 5'd15), 1, 0, 0,
          2'd3, 5'd8, 4'd6, 5'd9, 5'd15);
    check("R4", "all active lanes", vm[15], vm[9]);
    issue("R4 word", enc(2'd2, 5'd8, 4'd7, 5'd9, 5'd16), 1, 0, 0,
          2'd2, 5'd8, 4'd7, 5'd9, 5'd16);
    issue("R4 half", enc(2'd1, 5'd8, 4'd5, 5'd9, 5'd17), 1, 0, 0,
          2'd1, 5'd8, 4'd5, 5'd9, 5'd17);
  endtask

  task automatic t_alias_overlap;
    issue("R6 alias", enc(2'd0, 5'd25, 4'd3, 5'd26, 5'd25), 1, 0, 1,
          2'd0, 5'd25, 4'd3, 5'd26, 5'd25);
    issue("R8 dest=first src", enc(2'd1, 5'd27, 4'd4, 5'd28, 5'd28), 1, 0, 0,
          2'd1, 5'd27, 4'd4, 5'd28, 5'd28);
  endtask

  task automatic t_undef;
    logic [31:0] good;
    good = enc(2'd0, 5'd1, 4'd3, 5'd2, 5'd30);
    issue("R1 bit31", good ^ 32'h8000_0000, 1, 1, 0, 2'd0, 5'd1, 4'd3, 5'd2, 5'd30);
    issue("R1 bit21", good ^ 32'h0020_0000, 1, 1, 0, 2'd0, 5'd1, 4'd3, 5'd2, 5'd30);
    issue("R1 bit14", good ^ 32'h0000_4000, 1, 1, 0, 2'd0, 5'd1, 4'd3, 5'd2, 5'd30);
    issue("R7 disabled", enc(2'd0, 5'd30, 4'd3, 5'd2, 5'd30), 0, 1, 0,
          2'd0, 5'd30, 4'd3, 5'd2, 5'd30);
  endtask

  task automatic t_b2b;
    logic [127:0] e1, e2;
    e1 = exp_sel(2'd2, pm[3], vm[4], vm[5]);
    e2 = exp_sel(2'd0, pm[4], vm[11], vm[12]);
    @(negedge clk);
    in_valid = 1; in_instr = enc(2'd2, 5'd5, 4'd3, 5'd4, 5'd31);
    @(negedge clk);
    check("R9", "done b2b first", 128'(out_done), 1);
    in_instr = enc(2'd0, 5'd12, 4'd4, 5'd11, 5'd29);
    @(negedge clk);
    check("R9", "done b2b second", 128'(out_done), 1);
    in_valid = 0;
    vm[31] = e1; vm[29] = e2;
    @(negedge clk);
    check("R9", "done idle", 128'(out_done), 0);
    read_v(31, "R9");
    read_v(29, "R9");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!summary_done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary_done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; unit_en = 1; in_valid = 0; in_instr = '0;
    pl_v_we = 0; pl_v_idx = '0; pl_v_data = '0;
    pl_p_we = 0; pl_p_idx = '0; pl_p_data = '0; rb_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_preload();
    t_sizes();
    t_lowbit();
    t_alias_overlap();
    t_undef();
    t_b2b();
    if (!summary_done) begin
      summary_done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule